// File: doc/BRIEF.md
# I2C Byte-Completion Pending Flag

This block keeps the byte-level interrupt state of an I2C controller. It holds an active-low pending flag that sits at 1 while nothing is pending. The flag drops to 0 when a byte transfer has finished, and it drops on the falling edge of the last transfer clock of that byte. Depending on a mode bit, the last clock is either the eighth data clock or the ninth (acknowledge) clock. A small internal bit counter follows the falling edges of the controller's transfer clock to find that edge.

The flag drops only if a qualifying status event was reported during the byte. Qualifying events are:
- a byte was sent, including one that ended in lost arbitration;
- a byte was received;
- in slave-receive mode, a matched slave or general-call address, or, in free format, any received address byte.

While the flag is 0 the block asks the clock generator to hold SCL low. When the flag falls, the block raises a one-cycle interrupt pulse.

Software returns the flag to 1 by writing the data register, by disabling the peripheral or by pulsing its soft reset. A write to the clock-control register also returns the flag to 1, but only in a held receive under wait mode. Wait mode is selected when the acknowledge-clock option and the wait option are both set. In that mode a received byte raises an early request at the eighth clock. After software releases it, a second request follows on the acknowledge clock.

Top module: `i2c_byte_pend`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge) `pend_n` is 1, `irq` is 0 and `scl_hold` is 0.
- R2: A `tx_done` or `arb_lost` strobe during a byte makes `pend_n` fall at the last transfer-clock falling edge (`scl_fall` strobe) of that byte, and not earlier. The last edge is the 8th when `ack_opt` is 0 and the 9th when `ack_opt` is 1.
- R3: An `rx_done` strobe during a byte makes `pend_n` fall at that byte's last transfer-clock edge, as defined in R2.
- R4: With `slave_rx` at 1, a strobe can make `pend_n` fall at the last edge in either address format. With `free_fmt` at 0, `addr_hit` or `gcall_hit` does this. With `free_fmt` at 1, only `free_addr` does this, and `addr_hit` is ignored.
- R5: A `wr_data` strobe returns `pend_n` to 1 on the following clock edge.
- R6: While `en` is 0 or `sw_rst` is 1, `pend_n` returns to 1 and the bit count and any recorded status are discarded. The next byte then needs a full set of transfer clocks.
- R7: A `wr_clkctl` strobe returns `pend_n` to 1 only when `wait_opt` is 1 and a wait-mode receive hold is active. In every other case it has no effect.
- R8: When `ack_opt` and `wait_opt` are both 1, a received byte drops `pend_n` at the 8th edge. After a `wr_clkctl` release, `pend_n` drops again at the 9th (acknowledge) edge.
- R9: `irq` is 1 for exactly one clock cycle, in the cycle in which `pend_n` first reads 0 after being 1, and at no other time.
- R10: `scl_hold` is 1 exactly while `pend_n` is 0. `scl_fall` strobes arriving while the hold is active are not counted.
- R11: If a release (R5, R6, R7) and a completion fall to 0 coincide in one cycle, the release wins. `pend_n` stays 1 and `irq` stays 0.
- R12: A byte whose last edge passes with no qualifying status strobe leaves `pend_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Peripheral enable; 0 releases the flag and clears the state |
| sw_rst | input | 1 | Peripheral soft reset; 1 releases the flag and clears the state |
| ack_opt | input | 1 | 1: the acknowledge (9th) clock is the last clock; 0: the 8th clock is the last |
| wait_opt | input | 1 | Wait option: early receive request plus clock-control release |
| free_fmt | input | 1 | 1: free address format; 0: addressing format |
| slave_rx | input | 1 | Controller is in slave-receive mode |
| wr_data | input | 1 | One-cycle strobe: software wrote the data register |
| wr_clkctl | input | 1 | One-cycle strobe: software wrote the clock-control register |
| scl_fall | input | 1 | One-cycle strobe: falling edge of the internal transfer clock |
| tx_done | input | 1 | Status strobe: a byte was transmitted |
| rx_done | input | 1 | Status strobe: a byte was received |
| arb_lost | input | 1 | Status strobe: a transmitted byte lost arbitration |
| addr_hit | input | 1 | Status strobe: own slave address matched |
| gcall_hit | input | 1 | Status strobe: general-call address received |
| free_addr | input | 1 | Status strobe: address byte received in free format |
| pend_n | output | 1 | Active-low pending flag |
| irq | output | 1 | One-cycle interrupt request on the flag's 1-to-0 transition |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The assertions assume that every input strobe is one system clock wide. They also assume that `scl_fall` only pulses while the clock generator is running, never while `scl_hold` is asserted. Finally, they assume the mode bits (`ack_opt`, `wait_opt`, `free_fmt`, `slave_rx`) do not change within a byte. The bench keeps to all three assumptions. It raises each strobe for a single cycle from one falling clock edge to the next. It separates transfer-clock strobes with an idle cycle and only issues them while the flag is 1. It sets mode bits only between bytes, when the bit count has returned to zero.

// File: rtl/i2c_pend_pkg.sv
// Package: shared types for the I2C byte-completion pending flag.
// Assumes nothing beyond being compiled before the modules that import it.
package i2c_pend_pkg;

    // Status strobes reported by the shift and address logic.
    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic arb_lost;
        logic addr_hit;
        logic gcall_hit;
        logic free_addr;
    } xfer_stat_t;

    // Which transfer-clock edge (if any) the current strobe is.
    typedef enum logic [1:0] {
        EDGE_NONE   = 2'd0,
        EDGE_EIGHTH = 2'd1,
        EDGE_ACK    = 2'd2
    } clk_edge_e;

endpackage

// File: rtl/i2c_bitcount.sv
// Module: i2c_bitcount
// Counts falling edges of the transfer clock within a byte and classifies the
// current strobe as the last data-bit edge, the acknowledge edge, or neither.
// Assumes tick is a one-cycle strobe and ack_opt is steady within a byte.
module i2c_bitcount
    import i2c_pend_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int CNT_W     = $clog2(DATA_BITS + 2)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      tick,
    input  logic      ack_opt,
    output clk_edge_e edge_kind
);

    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(DATA_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wrap_at;

    // Select the count value at which the byte ends.
    always_comb begin
        wrap_at = ack_opt ? ACK_POS : LAST_DATA;
    end

    // Classify the strobe by the position it lands on.
    always_comb begin
        edge_kind = EDGE_NONE;
        if (tick) begin
            if (cnt_q == LAST_DATA) begin
                edge_kind = EDGE_EIGHTH;
            end else if (ack_opt && (cnt_q == ACK_POS)) begin
                edge_kind = EDGE_ACK;
            end
        end
    end

    // Advance on each counted edge and wrap at the end of the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q >= wrap_at) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/i2c_cause_latch.sv
// Module: i2c_cause_latch
// Records whether a qualifying status strobe arrived during the current byte,
// and separately whether it was a receive, until the byte's last edge.
// Assumes slave_rx and free_fmt are steady within a byte.
module i2c_cause_latch
    import i2c_pend_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       end_byte,
    input  logic       slave_rx,
    input  logic       free_fmt,
    input  xfer_stat_t stat,
    output logic       done_any,
    output logic       rx_any
);

    logic done_q;
    logic rx_q;
    logic addr_ok;
    logic done_now;
    logic rx_now;

    // Qualify the address strobes by the active format.
    always_comb begin
        if (free_fmt) begin
            addr_ok = slave_rx && stat.free_addr;
        end else begin
            addr_ok = slave_rx && (stat.addr_hit || stat.gcall_hit);
        end
        rx_now   = stat.rx_done || addr_ok;
        done_now = stat.tx_done || stat.arb_lost || rx_now;
        done_any = done_q || done_now;
        rx_any   = rx_q || rx_now;
    end

    // Hold the recorded causes until the byte ends or the block is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || end_byte) begin
            done_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            done_q <= done_any;
            rx_q   <= rx_any;
        end
    end

endmodule

// File: rtl/i2c_fall_pulse.sv
// Module: i2c_fall_pulse
// Produces a one-cycle pulse in the first cycle a level reads 0 after 1.
// Assumes the level is registered and resets to 1.
module i2c_fall_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);

    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= lvl;
        end
    end

    // Flag the 1-to-0 transition.
    always_comb begin
        pulse = prev_q && !lvl;
    end

endmodule

// File: rtl/i2c_byte_pend.sv
// Module: i2c_byte_pend (top)
// Active-low byte-completion pending flag with SCL hold and interrupt pulse.
// Software releases the flag with priority over a completion in the same cycle.
// Assumes one-cycle strobes, and no scl_fall strobe while scl_hold is high
// (such strobes are ignored).
module i2c_byte_pend
    import i2c_pend_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sw_rst,
    input  logic ack_opt,
    input  logic wait_opt,
    input  logic free_fmt,
    input  logic slave_rx,
    input  logic wr_data,
    input  logic wr_clkctl,
    input  logic scl_fall,
    input  logic tx_done,
    input  logic rx_done,
    input  logic arb_lost,
    input  logic addr_hit,
    input  logic gcall_hit,
    input  logic free_addr,
    output logic pend_n,
    output logic irq,
    output logic scl_hold
);

    localparam int CNT_W = $clog2(DATA_BITS + 2);

    logic       pend_q;
    logic       wait_q;
    logic       off;
    logic       ack_wait;
    logic       tick;
    clk_edge_e  edge_kind;
    logic       at_eighth;
    logic       at_ack;
    logic       last_edge;
    logic       done_any;
    logic       rx_any;
    logic       ctl_release;
    logic       set_req;
    logic       early_rx;
    logic       clr_req;
    xfer_stat_t stat;

    // Gather the status strobes and the mode conditions.
    always_comb begin
        stat.tx_done   = tx_done;
        stat.rx_done   = rx_done;
        stat.arb_lost  = arb_lost;
        stat.addr_hit  = addr_hit;
        stat.gcall_hit = gcall_hit;
        stat.free_addr = free_addr;
        off            = !en || sw_rst;
        ack_wait       = ack_opt && wait_opt;
        tick           = scl_fall && pend_q;
    end

    i2c_bitcount #(
        .DATA_BITS (DATA_BITS),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (off),
        .tick      (tick),
        .ack_opt   (ack_opt),
        .edge_kind (edge_kind)
    );

    // Decode the byte-end edge for the selected mode.
    always_comb begin
        at_eighth = (edge_kind == EDGE_EIGHTH);
        at_ack    = (edge_kind == EDGE_ACK);
        last_edge = ack_opt ? at_ack : at_eighth;
    end

    i2c_cause_latch u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (off),
        .end_byte (last_edge),
        .slave_rx (slave_rx),
        .free_fmt (free_fmt),
        .stat     (stat),
        .done_any (done_any),
        .rx_any   (rx_any)
    );

    // Form the release and completion requests.
    always_comb begin
        ctl_release = wr_clkctl && wait_opt && wait_q;
        set_req     = wr_data || off || ctl_release;
        early_rx    = ack_wait && at_eighth && rx_any;
        clr_req     = (last_edge && done_any) || early_rx;
    end

    // Pending flag: release has priority over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
        end else if (set_req) begin
            pend_q <= 1'b1;
        end else if (clr_req) begin
            pend_q <= 1'b0;
        end
    end

    // Wait-mode receive hold: set at the early request, cleared by release or ack edge.
    always_ff @(posedge clk) begin
        if (!rst_n || off) begin
            wait_q <= 1'b0;
        end else if (early_rx && !set_req) begin
            wait_q <= 1'b1;
        end else if (ctl_release || at_ack) begin
            wait_q <= 1'b0;
        end
    end

    i2c_fall_pulse u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pend_q),
        .pulse (irq)
    );

    // Drive the flag and the SCL hold request.
    always_comb begin
        pend_n   = pend_q;
        scl_hold = !pend_q;
    end

endmodule

// File: rtl/i2c_byte_pend_chk.sv
// Module: i2c_byte_pend_chk
// Temporal checks on the pending flag, interrupt pulse and hold request.
// Assumes one-cycle strobes and no transfer-clock strobes while SCL is held.
module i2c_byte_pend_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sw_rst,
    input logic wait_opt,
    input logic wr_data,
    input logic wr_clkctl,
    input logic scl_fall,
    input logic pend_n,
    input logic irq,
    input logic scl_hold
);

    // R2: the flag only falls at a transfer-clock edge
    assert_fall_on_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_n) |-> $past(scl_fall));

    // R5: a data write releases the flag
    assert_data_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> pend_n);

    // R6: disable or soft reset releases the flag
    assert_off_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || sw_rst) |=> pend_n);

    // R7: a clock-control write has no effect without the wait option
    assert_ctl_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_n && wr_clkctl && !wait_opt && !wr_data && en && !sw_rst) |=> !pend_n);

    // R9: every fall raises the pulse
    assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_n) |-> irq);

    // R9: the pulse lasts one cycle
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: the hold request starts together with the interrupt
    assert_hold_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> irq);

endmodule

bind i2c_byte_pend i2c_byte_pend_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sw_rst    (sw_rst),
    .wait_opt  (wait_opt),
    .wr_data   (wr_data),
    .wr_clkctl (wr_clkctl),
    .scl_fall  (scl_fall),
    .pend_n    (pend_n),
    .irq       (irq),
    .scl_hold  (scl_hold)
);

// File: tb/i2c_byte_pend_bench.sv
// Directed bench for i2c_byte_pend: one task per scenario.
module i2c_byte_pend_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, sw_rst = 1'b0, ack_opt = 1'b0, wait_opt = 1'b0;
    logic free_fmt = 1'b0, slave_rx = 1'b0;
    logic wr_data = 1'b0, wr_clkctl = 1'b0, scl_fall = 1'b0;
    logic tx_done = 1'b0, rx_done = 1'b0, arb_lost = 1'b0;
    logic addr_hit = 1'b0, gcall_hit = 1'b0, free_addr = 1'b0;
    logic pend_n, irq, scl_hold;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    i2c_byte_pend u_i2c_byte_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sw_rst    (sw_rst),
        .ack_opt   (ack_opt),
        .wait_opt  (wait_opt),
        .free_fmt  (free_fmt),
        .slave_rx  (slave_rx),
        .wr_data   (wr_data),
        .wr_clkctl (wr_clkctl),
        .scl_fall  (scl_fall),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .arb_lost  (arb_lost),
        .addr_hit  (addr_hit),
        .gcall_hit (gcall_hit),
        .free_addr (free_addr),
        .pend_n    (pend_n),
        .irq       (irq),
        .scl_hold  (scl_hold)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One clock: return at the next falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic falls(input int n);
        for (int i = 0; i < n; i++) begin
            scl_fall = 1'b1;
            tick();
            scl_fall = 1'b0;
            tick();
        end
    endtask

    // One transfer-clock edge, then check flag, pulse and hold.
    task automatic edge_check(input string tag, input logic exp_pend);
        scl_fall = 1'b1;
        tick();
        scl_fall = 1'b0;
        chk({tag, " pend_n"}, pend_n, exp_pend);
        chk({tag, " irq"}, irq, !exp_pend);
        chk({tag, " scl_hold"}, scl_hold, !exp_pend);
        tick();
        chk({tag, " irq drop"}, irq, 1'b0);
    endtask

    task automatic release_data(input string tag);
        wr_data = 1'b1;
        tick();
        wr_data = 1'b0;
        chk(tag, pend_n, 1'b1);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 pend_n", pend_n, 1'b1);
        chk("R1 irq", irq, 1'b0);
        chk("R1 scl_hold", scl_hold, 1'b0);
    endtask

    task automatic t_tx_eighth();
        ack_opt = 1'b0;
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        falls(7);
        chk("R2 before 8th", pend_n, 1'b1);
        edge_check("R2 R9 R10 tx at 8th", 1'b0);
        release_data("R5 data write release");
        arb_lost = 1'b1; tick(); arb_lost = 1'b0;
        falls(7);
        edge_check("R2 arb lost at 8th", 1'b0);
        release_data("R5 release after arb");
    endtask

    task automatic t_rx_ack();
        ack_opt = 1'b1;
        rx_done = 1'b1; tick(); rx_done = 1'b0;
        falls(8);
        chk("R3 before ack clock", pend_n, 1'b1);
        edge_check("R3 rx at ack clock", 1'b0);
        release_data("R5 release after rx");
        ack_opt = 1'b0;
    endtask

    task automatic t_address();
        slave_rx = 1'b1;
        free_fmt = 1'b0;
        gcall_hit = 1'b1; tick(); gcall_hit = 1'b0;
        falls(7);
        edge_check("R4 general call", 1'b0);
        release_data("R5 release gcall");
        addr_hit = 1'b1; tick(); addr_hit = 1'b0;
        falls(7);
        edge_check("R4 address match", 1'b0);
        release_data("R5 release addr");
        free_fmt = 1'b1;
        addr_hit = 1'b1; tick(); addr_hit = 1'b0;
        falls(7);
        edge_check("R4 match ignored in free format", 1'b1);
        free_addr = 1'b1; tick(); free_addr = 1'b0;
        falls(7);
        edge_check("R4 free format address", 1'b0);
        release_data("R5 release free");
        free_fmt = 1'b0;
        slave_rx = 1'b0;
    endtask

    task automatic t_idle_byte();
        falls(7);
        edge_check("R12 no status", 1'b1);
    endtask

    task automatic t_disable();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        falls(4);
        en = 1'b0; tick(); en = 1'b1;
        chk("R6 disable keeps flag", pend_n, 1'b1);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        falls(7);
        chk("R6 count restarted", pend_n, 1'b1);
        edge_check("R6 full byte after restart", 1'b0);
        sw_rst = 1'b1; tick(); sw_rst = 1'b0;
        chk("R6 soft reset releases", pend_n, 1'b1);
        tick();
    endtask

    task automatic t_ctl_noeffect();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        falls(7);
        edge_check("R7 setup", 1'b0);
        wr_clkctl = 1'b1; tick(); wr_clkctl = 1'b0;
        chk("R7 ctl write ignored", pend_n, 1'b0);
        release_data("R5 release after R7");
    endtask

    task automatic t_wait_mode();
        ack_opt = 1'b1;
        wait_opt = 1'b1;
        rx_done = 1'b1; tick(); rx_done = 1'b0;
        falls(7);
        edge_check("R8 early rx request", 1'b0);
        wr_clkctl = 1'b1; tick(); wr_clkctl = 1'b0;
        chk("R7 R8 ctl release", pend_n, 1'b1);
        tick();
        edge_check("R8 ack clock request", 1'b0);
        release_data("R5 release wait");
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        falls(7);
        edge_check("R8 tx no early request", 1'b1);
        edge_check("R8 tx at ack", 1'b0);
        wr_clkctl = 1'b1; tick(); wr_clkctl = 1'b0;
        chk("R7 no hold active", pend_n, 1'b0);
        release_data("R5 release tx wait");
        ack_opt = 1'b0;
        wait_opt = 1'b0;
    endtask

    task automatic t_priority();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        falls(7);
        wr_data = 1'b1;
        scl_fall = 1'b1;
        tick();
        wr_data = 1'b0;
        scl_fall = 1'b0;
        chk("R11 release wins", pend_n, 1'b1);
        chk("R11 no irq", irq, 1'b0);
        tick();
        chk("R11 no later irq", irq, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_tx_eighth();
        t_rx_ack();
        t_address();
        t_idle_byte();
        t_disable();
        t_ctl_noeffect();
        t_wait_mode();
        t_priority();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule